// File: doc/BRIEF.md
# Address-Range Memory Protection Checker

This block sits in front of a memory controller and decides, for each incoming transaction, whether it may proceed. It holds a table of protection rules. Each rule names a range of 1 MiB address regions, an inclusive range of transaction IDs, the set of ports it covers and the security states it covers. Each rule also carries a verdict bit. A transaction is compared against every rule at once. The lowest-numbered valid rule that matches supplies the verdict. When no rule matches, a per-port default register decides.

Software never writes rule entries directly. It fills three staging registers (region bounds, ID bounds and rule attributes) and then writes a rule number, with a commit bit, to the control register. The same control register, written with a load bit, copies a rule back into the staging registers so that it can be read. The verdict is registered and appears one cycle after the request. A typical sequence is to clear every rule, install an accepting rule that covers the populated memory, and then set the default register to reject everything else.

Top module: `mem_prot_filter`

## Requirements
- R1: After reset, every rule is invalid, the default register and all staging registers read 0, and every request on a port below NUM_PORTS is allowed.
- R2: Configuration offsets are 0 for control, 1 for staged bounds, 2 for staged IDs, 3 for staged attributes and 4 for the default register. A control write whose bit 5 is set copies the three staging registers into the rule numbered by bits 4:0. Control reads return the last written rule number in bits 4:0.
- R3: A control write whose bit 6 is set, and whose bit 5 is clear, copies the numbered rule into the staging registers, where offsets 1 to 3 read it back.
- R4: Staged bounds hold the first region in bits 11:0 and the last included region in bits 23:12, where a region is address bits 31:20. A request matches when its region lies in that range, with both ends included.
- R5: Staged IDs hold the lowest ID in bits 11:0 and the highest in bits 23:12, and a request ID matches within that range, with both ends included.
- R6: Attribute bits 12:3 form a port mask. Port p matches only when bit 3+p is set.
- R7: Attribute bits 1:0 select the security states: bit 0 admits secure requests and bit 1 admits non-secure ones.
- R8: A rule takes part in matching only when attribute bit 2 (valid) is set. A matching rule allows the request when attribute bit 13 is 0 and denies it when that bit is 1.
- R9: When several valid rules match, the lowest-numbered one decides.
- R10: When no rule matches, bit p of the default register decides for port p: 1 denies and 0 allows.
- R11: Each request cycle yields resp_valid exactly one cycle later, carrying that request's verdict. Rule changes committed in the same cycle do not affect that verdict.
- R12: Commit and load with a rule number of NUM_RULES or above change no rule and no staging register.
- R13: A request whose port index is NUM_PORTS or above is denied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register offset |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data for cfg_addr, combinational |
| req_valid | input | 1 | Transaction present |
| req_addr | input | 32 | Transaction byte address |
| req_id | input | 12 | Transaction ID |
| req_port | input | 4 | Index of the originating port |
| req_secure | input | 1 | 1 for a secure transaction |
| resp_valid | output | 1 | Verdict present, one cycle after req_valid |
| resp_allow | output | 1 | 1 allows, 0 denies |

## Verification
The bench builds the block with its default parameters: 20 rules, 10 ports, 32-bit addresses with 1 MiB regions, and 12-bit IDs. With these values the range ends at region 0x000 and 0xFFF, ID 0 and 0xFFF, and the first invalid rule numbers 20 and 31 can all be reached from the bench. They also expose port indices 10 to 15, which the 4-bit port field can carry but no rule can cover. Directed sequences cover each range edge, each security setting, overlapping rules in both priority orders and out-of-range commands. After these, a long run of mixed requests overlaps many rules.

// File: rtl/mem_prot_filter.sv
module mem_prot_filter #(
  parameter int NUM_RULES    = 20,
  parameter int NUM_PORTS    = 10,
  parameter int ADDR_W       = 32,
  parameter int REGION_SHIFT = 20,
  parameter int ID_W         = 12,
  parameter int CFG_W        = 32,
  localparam int PORT_W      = $clog2(NUM_PORTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CFG_W-1:0]  cfg_rdata,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ID_W-1:0]   req_id,
  input  logic [PORT_W-1:0] req_port,
  input  logic              req_secure,
  output logic              resp_valid,
  output logic              resp_allow
);

  localparam int RGN_W   = ADDR_W - REGION_SHIFT;
  localparam int SEL_W   = 5;
  localparam int BIT_COMMIT = 5;
  localparam int BIT_LOAD   = 6;
  localparam int VLD_BIT = 2;
  localparam int PM_LSB  = 3;
  localparam int RES_BIT = PM_LSB + NUM_PORTS;
  localparam int DAT_W   = RES_BIT + 1;

  localparam logic [2:0] OFS_CTL  = 3'd0;
  localparam logic [2:0] OFS_BND  = 3'd1;
  localparam logic [2:0] OFS_IDS  = 3'd2;
  localparam logic [2:0] OFS_ATTR = 3'd3;
  localparam logic [2:0] OFS_DFLT = 3'd4;

  logic [SEL_W-1:0]     sel_q;
  logic [2*RGN_W-1:0]   stg_bnd;
  logic [2*ID_W-1:0]    stg_ids;
  logic [DAT_W-1:0]     stg_attr;
  logic [NUM_PORTS-1:0] dflt_q;

  logic [2*RGN_W-1:0]   tbl_bnd  [NUM_RULES];
  logic [2*ID_W-1:0]    tbl_ids  [NUM_RULES];
  logic [DAT_W-1:0]     tbl_attr [NUM_RULES];

  logic [NUM_RULES-1:0] rule_vld;
  logic [NUM_RULES-1:0] hit;

  wire              wr_ctl  = cfg_we && (cfg_addr == OFS_CTL);
  wire [SEL_W-1:0]  cmd_idx = cfg_wdata[SEL_W-1:0];
  wire              idx_ok  = int'(cmd_idx) < NUM_RULES;
  wire              do_commit = wr_ctl && cfg_wdata[BIT_COMMIT] && idx_ok;
  wire              do_load   = wr_ctl && cfg_wdata[BIT_LOAD] && !cfg_wdata[BIT_COMMIT] && idx_ok;

  wire [RGN_W-1:0]  req_rgn = req_addr[ADDR_W-1 -: RGN_W];
  wire              port_ok = int'(req_port) < NUM_PORTS;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q    <= '0;
      stg_bnd  <= '0;
      stg_ids  <= '0;
      stg_attr <= '0;
      dflt_q   <= '0;
    end else if (do_load) begin
      sel_q    <= cmd_idx;
      stg_bnd  <= tbl_bnd[cmd_idx];
      stg_ids  <= tbl_ids[cmd_idx];
      stg_attr <= tbl_attr[cmd_idx];
    end else if (cfg_we) begin
      case (cfg_addr)
        OFS_CTL:  sel_q    <= cmd_idx;
        OFS_BND:  stg_bnd  <= cfg_wdata[2*RGN_W-1:0];
        OFS_IDS:  stg_ids  <= cfg_wdata[2*ID_W-1:0];
        OFS_ATTR: stg_attr <= cfg_wdata[DAT_W-1:0];
        OFS_DFLT: dflt_q   <= cfg_wdata[NUM_PORTS-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    cfg_rdata = '0;
    case (cfg_addr)
      OFS_CTL:  cfg_rdata[SEL_W-1:0]   = sel_q;
      OFS_BND:  cfg_rdata[2*RGN_W-1:0] = stg_bnd;
      OFS_IDS:  cfg_rdata[2*ID_W-1:0]  = stg_ids;
      OFS_ATTR: cfg_rdata[DAT_W-1:0]   = stg_attr;
      OFS_DFLT: cfg_rdata[NUM_PORTS-1:0] = dflt_q;
      default: ;
    endcase
  end

  for (genvar i = 0; i < NUM_RULES; i++) begin : g_rule
    always_ff @(posedge clk) begin
      if (rst) begin
        tbl_bnd[i]  <= '0;
        tbl_ids[i]  <= '0;
        tbl_attr[i] <= '0;
      end else if (do_commit && cmd_idx == SEL_W'(i)) begin
        tbl_bnd[i]  <= stg_bnd;
        tbl_ids[i]  <= stg_ids;
        tbl_attr[i] <= stg_attr;
      end
    end

    wire [RGN_W-1:0]     lo_rgn = tbl_bnd[i][RGN_W-1:0];
    wire [RGN_W-1:0]     hi_rgn = tbl_bnd[i][2*RGN_W-1:RGN_W];
    wire [ID_W-1:0]      lo_id  = tbl_ids[i][ID_W-1:0];
    wire [ID_W-1:0]      hi_id  = tbl_ids[i][2*ID_W-1:ID_W];
    wire [NUM_PORTS-1:0] pmask  = tbl_attr[i][PM_LSB +: NUM_PORTS];
    wire                 sec_ok = req_secure ? tbl_attr[i][0] : tbl_attr[i][1];

    assign rule_vld[i] = tbl_attr[i][VLD_BIT];
    assign hit[i] = rule_vld[i] && port_ok && pmask[req_port] && sec_ok &&
                    (req_rgn >= lo_rgn) && (req_rgn <= hi_rgn) &&
                    (req_id >= lo_id) && (req_id <= hi_id);
  end

  logic deny_nxt;
  always_comb begin
    deny_nxt = port_ok ? dflt_q[req_port] : 1'b1;
    for (int i = NUM_RULES - 1; i >= 0; i--)
      if (hit[i]) deny_nxt = tbl_attr[i][RES_BIT];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= 1'b0;
      resp_allow <= 1'b0;
    end else begin
      resp_valid <= req_valid;
      resp_allow <= req_valid && !deny_nxt;
    end
  end

endmodule

// File: rtl/mem_prot_filter_sva.sv
module mem_prot_filter_sva #(
  parameter int NUM_RULES = 20,
  parameter int NUM_PORTS = 10,
  parameter int PORT_W    = 4,
  parameter int BND_W     = 24,
  parameter int IDS_W     = 24,
  parameter int ATTR_W    = 14
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 cfg_we,
  input logic [2:0]           cfg_addr,
  input logic [31:0]          cfg_wdata,
  input logic                 req_valid,
  input logic [PORT_W-1:0]    req_port,
  input logic                 resp_valid,
  input logic                 resp_allow,
  input logic [NUM_RULES-1:0] rule_vld,
  input logic [NUM_PORTS-1:0] dflt_q,
  input logic [BND_W-1:0]     stg_bnd,
  input logic [IDS_W-1:0]     stg_ids,
  input logic [ATTR_W-1:0]    stg_attr
);

  logic seen_commit;
  wire  ctl_commit = cfg_we && cfg_addr == 3'd0 && cfg_wdata[5];
  wire  port_ok    = int'(req_port) < NUM_PORTS;

  always_ff @(posedge clk) begin
    if (rst) seen_commit <= 1'b0;
    else if (ctl_commit) seen_commit <= 1'b1;
  end

  p_resp_follows_r11: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> resp_valid);
  p_resp_idle_r11: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !resp_valid && !resp_allow);
  p_reset_open_r1: assert property (@(posedge clk) disable iff (rst)
    (!seen_commit && dflt_q == '0 && req_valid && port_ok) |=> resp_allow);
  p_default_deny_r10: assert property (@(posedge clk) disable iff (rst)
    (rule_vld == '0 && req_valid && port_ok && dflt_q[req_port]) |=> !resp_allow);
  p_bad_port_r13: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !port_ok) |=> !resp_allow);
  p_stage_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !cfg_we |=> $stable({stg_bnd, stg_ids, stg_attr}));
  p_table_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !ctl_commit |=> $stable(rule_vld));

endmodule

bind mem_prot_filter mem_prot_filter_sva #(
  .NUM_RULES(NUM_RULES), .NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W),
  .BND_W(2*RGN_W), .IDS_W(2*ID_W), .ATTR_W(DAT_W)
) u_sva (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_port(req_port),
  .resp_valid(resp_valid), .resp_allow(resp_allow), .rule_vld(rule_vld),
  .dflt_q(dflt_q), .stg_bnd(stg_bnd), .stg_ids(stg_ids), .stg_attr(stg_attr)
);

// File: tb/mem_prot_filter_tb.sv
module mem_prot_filter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 20;
  localparam int NP = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [11:0] req_id = '0;
  logic [3:0]  req_port = '0;
  logic        req_secure = 1'b0;
  logic        resp_valid, resp_allow;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_prot_filter u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
    .req_addr(req_addr), .req_id(req_id), .req_port(req_port),
    .req_secure(req_secure), .resp_valid(resp_valid), .resp_allow(resp_allow)
  );

  int checks = 0;
  int errors = 0;
  string tag = "R1";
  bit finished = 0;

  logic [4:0]  m_sel;
  logic [23:0] m_bnd, m_ids;
  logic [13:0] m_attr;
  logic [9:0]  m_dflt;
  logic [23:0] t_bnd [NR];
  logic [23:0] t_ids [NR];
  logic [13:0] t_attr [NR];
  logic        exp_valid = 0, exp_allow = 0;

  function automatic logic model_allow(logic [31:0] a, logic [11:0] id, logic [3:0] p, logic s);
    if (p >= NP) return 1'b0;
    for (int i = 0; i < NR; i++) begin
      if (t_attr[i][2] && t_attr[i][3+p] && (s ? t_attr[i][0] : t_attr[i][1]) &&
          a[31:20] >= t_bnd[i][11:0] && a[31:20] <= t_bnd[i][23:12] &&
          id >= t_ids[i][11:0] && id <= t_ids[i][23:12])
        return !t_attr[i][13];
    end
    return !m_dflt[p];
  endfunction

  function automatic logic [31:0] model_read(logic [2:0] a);
    case (a)
      3'd0: return {27'd0, m_sel};
      3'd1: return {8'd0, m_bnd};
      3'd2: return {8'd0, m_ids};
      3'd3: return {18'd0, m_attr};
      3'd4: return {22'd0, m_dflt};
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_sel = '0; m_bnd = '0; m_ids = '0; m_attr = '0; m_dflt = '0;
    for (int i = 0; i < NR; i++) begin
      t_bnd[i] = '0; t_ids[i] = '0; t_attr[i] = '0;
    end
  endtask

  // At a falling edge: compare, drive, predict, advance model, wait one cycle.
  task automatic cyc(bit we, logic [2:0] ca, logic [31:0] cd,
                     bit rv, logic [31:0] ra, logic [11:0] rid, logic [3:0] rp, bit rs);
    chk("resp_valid", {31'd0, resp_valid}, {31'd0, exp_valid});
    chk("resp_allow", {31'd0, resp_allow}, {31'd0, exp_allow});
    chk("cfg_rdata", cfg_rdata, model_read(cfg_addr));
    cfg_we = we; cfg_addr = ca; cfg_wdata = cd;
    req_valid = rv; req_addr = ra; req_id = rid; req_port = rp; req_secure = rs;
    exp_valid = rv;
    exp_allow = rv && model_allow(ra, rid, rp, rs);
    if (we) begin
      case (ca)
        3'd0: begin
          m_sel = cd[4:0];
          if (cd[4:0] < NR) begin
            if (cd[5]) begin
              t_bnd[cd[4:0]] = m_bnd; t_ids[cd[4:0]] = m_ids; t_attr[cd[4:0]] = m_attr;
            end else if (cd[6]) begin
              m_bnd = t_bnd[cd[4:0]]; m_ids = t_ids[cd[4:0]]; m_attr = t_attr[cd[4:0]];
            end
          end
        end
        3'd1: m_bnd = cd[23:0];
        3'd2: m_ids = cd[23:0];
        3'd3: m_attr = cd[13:0];
        3'd4: m_dflt = cd[9:0];
        default: ;
      endcase
    end
    @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    cyc(1, a, d, 0, 0, 0, 0, 0);
  endtask

  task automatic rd(logic [2:0] a);
    cyc(0, a, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic rq(logic [31:0] a, logic [11:0] id, logic [3:0] p, bit s);
    cyc(0, 3'd7, 0, 1, a, id, p, s);
  endtask

  // sec: bits 1:0, result: bit 13, valid: bit 2, port mask 12:3
  task automatic put_rule(int n, logic [11:0] lo, logic [11:0] hi, logic [11:0] idlo,
                          logic [11:0] idhi, logic [9:0] pm, logic [1:0] sec, bit res, bit vld);
    wr(3'd1, {8'd0, hi, lo});
    wr(3'd2, {8'd0, idhi, idlo});
    wr(3'd3, {18'd0, res, pm, vld, sec});
    wr(3'd0, 32'(n) | 32'h20);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;

    tag = "R1";
    for (int a = 0; a < 8; a++) rd(3'(a));
    rq(32'h0000_0000, 12'h000, 0, 0);
    rq(32'hFFFF_FFFF, 12'hFFF, 9, 1);
    rq(32'h1234_5678, 12'h0AB, 5, 0);

    tag = "R11";
    for (int k = 0; k < 6; k++) if (k % 2 == 0) rq(32'h0100_0000 * k, 12'(k), 4'(k), 1); else rd(3'd0);

    tag = "R13";
    rq(32'h0, 0, 4'd10, 1);
    rq(32'h0, 0, 4'd15, 0);

    tag = "R2";
    put_rule(0, 12'h010, 12'h01F, 12'h000, 12'hFFF, 10'h3FF, 2'b11, 0, 1);
    wr(3'd4, 32'h3FF);
    rd(3'd0);
    tag = "R4";
    rq(32'h00FF_FFFF, 12'h5, 0, 1);
    rq(32'h0100_0000, 12'h5, 0, 1);
    rq(32'h01FF_FFFF, 12'h5, 9, 0);
    rq(32'h0200_0000, 12'h5, 1, 0);

    tag = "R5";
    put_rule(1, 12'h000, 12'hFFF, 12'h100, 12'h1FF, 10'h3FF, 2'b11, 0, 1);
    rq(32'h8000_0000, 12'h0FF, 2, 1);
    rq(32'h8000_0000, 12'h100, 2, 1);
    rq(32'h8000_0000, 12'h1FF, 2, 0);
    rq(32'h8000_0000, 12'h200, 2, 0);

    tag = "R6";
    put_rule(2, 12'h900, 12'h90F, 12'h000, 12'hFFF, 10'h010, 2'b11, 0, 1);
    rq(32'h9050_0000, 12'h300, 4, 1);
    rq(32'h9050_0000, 12'h300, 3, 1);
    rq(32'h9050_0000, 12'h300, 5, 0);

    tag = "R7";
    put_rule(3, 12'hA00, 12'hA00, 12'h000, 12'hFFF, 10'h3FF, 2'b01, 0, 1);
    rq(32'hA000_0000, 12'h300, 0, 1);
    rq(32'hA000_0000, 12'h300, 0, 0);
    put_rule(3, 12'hA00, 12'hA00, 12'h000, 12'hFFF, 10'h3FF, 2'b10, 0, 1);
    rq(32'hA000_0000, 12'h300, 0, 1);
    rq(32'hA000_0000, 12'h300, 0, 0);

    tag = "R8";
    wr(3'd4, 32'h0);
    put_rule(4, 12'hB00, 12'hB0F, 12'h000, 12'hFFF, 10'h3FF, 2'b11, 1, 1);
    rq(32'hB000_0000, 12'h300, 6, 1);
    rq(32'hB100_0000, 12'h300, 6, 1);
    wr(3'd4, 32'h3FF);
    put_rule(7, 12'hC00, 12'hC0F, 12'h000, 12'hFFF, 10'h3FF, 2'b11, 0, 0);
    rq(32'hC000_0000, 12'h300, 6, 1);

    tag = "R9";
    put_rule(5, 12'hD00, 12'hDFF, 12'h000, 12'hFFF, 10'h3FF, 2'b11, 1, 1);
    put_rule(6, 12'hD00, 12'hDFF, 12'h000, 12'hFFF, 10'h3FF, 2'b11, 0, 1);
    rq(32'hD800_0000, 12'h300, 1, 1);
    put_rule(5, 12'hD00, 12'hDFF, 12'h000, 12'hFFF, 10'h3FF, 2'b11, 0, 1);
    put_rule(6, 12'hD00, 12'hDFF, 12'h000, 12'hFFF, 10'h3FF, 2'b11, 1, 1);
    rq(32'hD800_0000, 12'h300, 1, 1);

    tag = "R10";
    wr(3'd4, 32'h005);
    for (int p = 0; p < 10; p++) rq(32'hF000_0000, 12'h300, 4'(p), p % 2);
    rd(3'd4);

    tag = "R11";
    cyc(1, 3'd0, 32'h0000_0028, 1, 32'hF000_0000, 12'h300, 1, 1);
    rq(32'hF000_0000, 12'h300, 1, 1);

    tag = "R3";
    wr(3'd1, 32'h00AB_CDEF);
    wr(3'd2, 32'h0012_3456);
    wr(3'd3, 32'h0000_1555);
    wr(3'd0, 32'h0000_0040);
    rd(3'd1); rd(3'd2); rd(3'd3); rd(3'd0);
    wr(3'd0, 32'h0000_0045);
    rd(3'd1); rd(3'd2); rd(3'd3);

    tag = "R12";
    wr(3'd1, 32'h0000_0000);
    wr(3'd2, 32'h00FF_F000);
    wr(3'd3, 32'h0000_3FFF);
    wr(3'd0, 32'h0000_0034);
    wr(3'd0, 32'h0000_003F);
    wr(3'd0, 32'h0000_0054);
    rd(3'd1); rd(3'd2); rd(3'd3); rd(3'd0);
    rq(32'h0000_0000, 12'h000, 0, 1);
    rq(32'hF000_0000, 12'hFFF, 0, 0);

    tag = "R9";
    for (int k = 0; k < 3000; k++) begin
      int r;
      r = $urandom_range(0, 9);
      if (r == 0)
        put_rule($urandom_range(0, 19), 12'($urandom_range(0, 15) << 8),
                 12'($urandom_range(0, 4095)), 12'($urandom_range(0, 2047)),
                 12'($urandom_range(1024, 4095)), 10'($urandom), 2'($urandom),
                 1'($urandom), 1'($urandom));
      else if (r == 1)
        wr(3'd4, $urandom);
      else if (r == 2)
        wr(3'd0, 32'($urandom_range(0, 31)) | 32'h40);
      else
        rq($urandom, 12'($urandom), 4'($urandom_range(0, 11)), 1'($urandom));
    end
    rd(3'd0);
    rd(3'd0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule